// File: doc/BRIEF.md
# NAND Read-Status Byte Tracker

This block sits inside a NAND flash device and keeps the 8-bit value that the device returns on a read-status or per-plane read-status request. An operation engine reports events to it: a new operation starting, array busy, data-cache busy, the pass/fail result of a page, and the moment when a cache program hands one page to the array and frees the cache for the next. The tracker also watches the live write-protect level and every command byte the command decoder latches.

From these inputs it builds the status byte. It reports array readiness and cache readiness as separate bits. It keeps pass/fail results for both the page in flight and the page before it across cache-program handoffs. It also tells the decoder which command bytes may be taken while the device is busy, and whether a program or erase request may start. A reset command issued while ready holds the device busy for a bounded number of cycles.

Top module: `nand_status_tracker`

## Requirements
- R1: Status bit 7 equals the live write-protect level (`wp_n_i`) in the same cycle, with no register: 0 means protected and 1 means not protected.
- R2: Status bit 6 (cache ready) is 0 while `cache_busy_i` is high or a reset busy period runs, and 1 otherwise. Status bit 5 (array ready) is 0 while `arr_busy_i` is high or a reset busy period runs, and 1 otherwise.
- R3: Status bits 4, 3 and 2 always read 0.
- R4: Status bit 0 shows the fail result (1 = fail) of the latest `page_done_i` for the current page. `op_start_i` clears it. During a cache program (after an accepted 15h since the last start or reset), bit 0 reads 0 unless bit 5 is 1.
- R5: A `cache_handoff_i` pulse moves the current-page result into the previous-page result and clears the current-page result. If `page_done_i` arrives in the same cycle, its result becomes the new current-page result.
- R6: Status bit 1 shows the previous-page result only once a second 15h has been accepted, or a 10h has been accepted after a 15h, since the last start or reset. Before that it reads 0.
- R7: While status bit 6 is 0, status bits 1 and 0 read 0.
- R8: `cmd_accept_o` is high when `cmd_valid_i` is high and either status bit 6 is 1 or the byte is FFh, 70h or 78h. All other bytes taken while bit 6 is 0 are ignored and change no state.
- R9: `op_go_o` is high only when `op_req_i` is high, `wp_n_i` is 1 and status bit 6 is 1.
- R10: An accepted FFh clears all stored results and the cache-program tracking. If it is accepted while bit 6 is 1, bits 6 and 5 read 0 for exactly `RST_CYCLES` cycles after the accepting edge. If it is accepted while busy, it adds no busy time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Live write-protect level, 0 = protected |
| arr_busy_i | input | 1 | Array operation in progress |
| cache_busy_i | input | 1 | Data cache register busy |
| op_start_i | input | 1 | Pulse: new operation starts, results clear |
| page_done_i | input | 1 | Pulse: current page finished |
| page_fail_i | input | 1 | Result that goes with `page_done_i`, 1 = fail |
| cache_handoff_i | input | 1 | Pulse: cache program hands a page to the array |
| cmd_valid_i | input | 1 | A command byte is presented |
| cmd_byte_i | input | 8 | Command byte |
| op_req_i | input | 1 | Program or erase start request |
| status_o | output | 8 | Status byte |
| cmd_accept_o | output | 1 | Presented command is taken |
| op_go_o | output | 1 | Program or erase may start |

## Verification
The bench sweeps all 256 command bytes in the ready state and in the busy state. A filter that let an extra byte through while busy, or dropped one of the three always-allowed bytes, would show up there. It walks a cache program from start to end. In that walk, a design that shows the previous-page bit before the second 15h, shows bit 0 while the array is busy, or fails to shift the result at a handoff reports the wrong page as failed. It also counts the exact length of the reset busy window and checks that FFh given while busy adds no busy time. An off-by-one counter, or a reset that restarts during an operation, gives a different cycle count.

// File: rtl/nand_status_tracker.sv
module nand_status_tracker #(
  parameter int RST_CYCLES = 500,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n_i,
  input  logic       arr_busy_i,
  input  logic       cache_busy_i,
  input  logic       op_start_i,
  input  logic       page_done_i,
  input  logic       page_fail_i,
  input  logic       cache_handoff_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  input  logic       op_req_i,
  output logic [7:0] status_o,
  output logic       cmd_accept_o,
  output logic       op_go_o
);

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_STATP = 8'h78;
  localparam logic [7:0] CMD_CACHE = 8'h15;
  localparam logic [7:0] CMD_FINAL = 8'h10;

  logic [CW-1:0] rst_cnt;
  logic          rst_busy;
  logic          cur_fail, prev_fail, prev_vis, in_cache;
  logic          cache_rdy, arr_rdy;
  logic          always_ok, acc;
  logic          acc_reset, acc_cache, acc_final;
  logic          bit0, bit1;

  assign rst_busy  = (rst_cnt != '0);
  assign cache_rdy = ~(cache_busy_i | rst_busy);
  assign arr_rdy   = ~(arr_busy_i | rst_busy);

  assign always_ok = (cmd_byte_i == CMD_RESET) || (cmd_byte_i == CMD_STAT) ||
                     (cmd_byte_i == CMD_STATP);
  assign acc       = cmd_valid_i & (cache_rdy | always_ok);
  assign acc_reset = acc & (cmd_byte_i == CMD_RESET);
  assign acc_cache = acc & (cmd_byte_i == CMD_CACHE);
  assign acc_final = acc & (cmd_byte_i == CMD_FINAL);

  assign cmd_accept_o = acc;
  assign op_go_o      = op_req_i & wp_n_i & cache_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
    end else if (acc_reset && cache_rdy) begin
      rst_cnt <= CW'(RST_CYCLES);
    end else if (rst_busy) begin
      rst_cnt <= rst_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_fail  <= 1'b0;
      prev_fail <= 1'b0;
      prev_vis  <= 1'b0;
      in_cache  <= 1'b0;
    end else if (acc_reset || op_start_i) begin
      cur_fail  <= 1'b0;
      prev_fail <= 1'b0;
      prev_vis  <= 1'b0;
      in_cache  <= 1'b0;
    end else begin
      if (cache_handoff_i) prev_fail <= cur_fail;
      if (page_done_i)          cur_fail <= page_fail_i;
      else if (cache_handoff_i) cur_fail <= 1'b0;
      if (acc_cache) in_cache <= 1'b1;
      if ((acc_cache || acc_final) && in_cache) prev_vis <= 1'b1;
    end
  end

  assign bit0 = cache_rdy & cur_fail & (arr_rdy | ~in_cache);
  assign bit1 = cache_rdy & prev_fail & prev_vis;

  assign status_o = {wp_n_i, cache_rdy, arr_rdy, 3'b000, bit1, bit0};

endmodule

// File: rtl/nand_status_tracker_chk.sv
module nand_status_tracker_chk #(
  parameter int RST_CYCLES = 500
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n_i,
  input logic       arr_busy_i,
  input logic       cache_busy_i,
  input logic       cmd_valid_i,
  input logic [7:0] cmd_byte_i,
  input logic       op_req_i,
  input logic [7:0] status_o,
  input logic       cmd_accept_o,
  input logic       op_go_o
);

  logic special;
  int   win;

  assign special = (cmd_byte_i == 8'hFF) || (cmd_byte_i == 8'h70) || (cmd_byte_i == 8'h78);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= 0;
    else if (cmd_accept_o && cmd_byte_i == 8'hFF && status_o[6]) win <= RST_CYCLES;
    else if (win != 0) win <= win - 1;
  end

  // R8
  busy_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !status_o[6] && !special) |-> !cmd_accept_o);

  // R8
  special_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && special) |-> cmd_accept_o);

  // R9
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_go_o |-> (wp_n_i && status_o[6] && op_req_i));

  // R7
  stale_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[6] |-> (status_o[1:0] == 2'b00));

  // R10
  reset_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win != 0) |-> (!status_o[6] && !status_o[5]));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 0 && !arr_busy_i && !cache_busy_i) |-> (status_o[6] && status_o[5]));

  // R3
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[4:2] == 3'b000);

endmodule

bind nand_status_tracker nand_status_tracker_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .arr_busy_i(arr_busy_i),
  .cache_busy_i(cache_busy_i), .cmd_valid_i(cmd_valid_i), .cmd_byte_i(cmd_byte_i),
  .op_req_i(op_req_i), .status_o(status_o), .cmd_accept_o(cmd_accept_o),
  .op_go_o(op_go_o)
);

// File: tb/tb_nand_status_tracker.sv
module tb_nand_status_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NRST = 6;

  logic clk = 0, rst_n = 0;
  logic wp_n = 1, arr_busy = 0, cache_busy = 0, op_start = 0;
  logic page_done = 0, page_fail = 0, handoff = 0, cmd_valid = 0, op_req = 0;
  logic [7:0] cmd_byte = 0;
  logic [7:0] status;
  logic accept, go;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_status_tracker #(.RST_CYCLES(NRST)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .arr_busy_i(arr_busy),
    .cache_busy_i(cache_busy), .op_start_i(op_start), .page_done_i(page_done),
    .page_fail_i(page_fail), .cache_handoff_i(handoff), .cmd_valid_i(cmd_valid),
    .cmd_byte_i(cmd_byte), .op_req_i(op_req), .status_o(status),
    .cmd_accept_o(accept), .op_go_o(go)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0 ] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] b);
    cmd_valid = 1; cmd_byte = b; step(); cmd_valid = 0;
  endtask

  task automatic done(logic f);
    page_done = 1; page_fail = f; step(); page_done = 0; page_fail = 0;
  endtask

  task automatic pulse_start();
    op_start = 1; step(); op_start = 0;
  endtask

  task automatic pulse_handoff();
    handoff = 1; step(); handoff = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    check("R2 reset state", status, 8'hE0);

    // R1 R2 R3 sweep of level inputs
    for (int i = 0; i < 8; i++) begin
      wp_n = i[2]; arr_busy = i[1]; cache_busy = i[0]; #1;
      check("R1 R2 R3 sweep", status, {i[2], ~i[0], ~i[1], 5'b0});
      step();
    end
    wp_n = 1; arr_busy = 0; cache_busy = 0; step();

    // R8 all bytes, ready and busy; no side effects (valid dropped before edge)
    for (int b2 = 0; b2 < 2; b2++) begin
      cache_busy = b2[0];
      for (int c = 0; c < 256; c++) begin
        logic exp;
        cmd_valid = 1; cmd_byte = c[7:0]; #1;
        exp = (b2 == 0) || c == 'hFF || c == 'h70 || c == 'h78;
        check("R8 byte filter", accept, exp);
        cmd_valid = 0; step();
      end
    end
    cache_busy = 0; step();
    check("R8 filter left state untouched", status, 8'hE0);

    // R9
    for (int i = 0; i < 8; i++) begin
      wp_n = i[2]; cache_busy = i[1]; op_req = i[0]; #1;
      check("R9 start gate", go, i[0] & i[2] & ~i[1]);
      op_req = 0; step();
    end
    wp_n = 1; cache_busy = 0; step();

    // R4 plain program
    pulse_start(); arr_busy = 1; cache_busy = 1;
    done(1);
    check("R7 hidden while busy", status[1:0], 2'b00);
    arr_busy = 0; cache_busy = 0; step();
    check("R4 fail shown", status, 8'hE1);
    wp_n = 0; #1;
    check("R1 protect with result", status, 8'h61);
    wp_n = 1;
    pulse_start();
    check("R4 start clears", status, 8'hE0);

    // cache program
    cmd(8'h15);
    arr_busy = 1; done(1);
    check("R4 bit0 hidden while array busy", status, 8'hC0);
    pulse_handoff();
    check("R6 bit1 hidden before second 15h", status, 8'hC0);
    cmd(8'h15);
    check("R6 bit1 after second 15h", status, 8'hC2);
    arr_busy = 0; done(0);
    check("R5 prev kept current pass", status, 8'hE2);
    done(1);
    check("R4 bit0 array ready", status, 8'hE3);
    cache_busy = 1; step();
    check("R7 stale results hidden", status, 8'hA0);
    cache_busy = 0; cmd(8'h10);
    check("R6 after 10h", status, 8'hE3);
    pulse_handoff();
    check("R5 handoff shift", status, 8'hE2);
    handoff = 1; page_done = 1; page_fail = 1; step();
    handoff = 0; page_done = 0; page_fail = 0;
    check("R5 handoff with same-cycle result", status, 8'hE1);

    // R10 reset in ready
    begin
      int n = 0;
      cmd(8'hFF);
      while (status[6] == 0 && n < 100) begin
        check("R10 both ready bits low", status[6:5], 2'b00);
        n++; step();
      end
      check("R10 reset busy length", n, NRST);
      check("R10 results cleared", status, 8'hE0);
    end

    // R10 reset while busy adds no busy time; clears results
    arr_busy = 1; done(1); cache_busy = 1; cmd(8'hFF);
    arr_busy = 0; cache_busy = 0; #1;
    check("R10 no busy from reset while busy", status, 8'hE0);
    step();
    check("R10 still ready", status, 8'hE0);

    // R6 plain 10h without 15h keeps bit1 off
    pulse_start(); done(1); pulse_handoff(); cmd(8'h10);
    check("R6 no cache no bit1", status, 8'hE0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule